// File: doc/BRIEF.md
# DDR SDRAM Mode Register Capture Unit

This block sits on the device side of a DDR SDRAM command bus and captures the mode register. Each rising clock edge it samples chip select, row strobe, column strobe, write enable and clock enable. When all four strobes are low and clock enable has been high on this edge and the one before, it treats the address and bank bits sampled on that edge as a register write. Bank bit 0 chooses the target: the extended register, of which only a written-once flag is kept, or the mode register, which it checks and decodes into burst length, burst type, CAS latency, test mode and a DLL reset request.

A write is accepted only when every bank is idle, when no earlier write is still inside its minimum settle window, and, for the mode register, when the extended register has already been written and every field holds a supported code. A refused write leaves all stored values as they were and raises a one-cycle error. An accepted write holds the busy output high until the settle window has passed, and any command seen while busy is refused. All outputs are registered and change on the edge that samples the command.

Top module: `sdr_mode_capture`

## Requirements
- R1: While reset is applied and after it is released, cfg_valid, cfg_err, busy and dll_rst are all low until a command is sampled.
- R2: A mode write (sel_n, row_strobe_n, col_strobe_n and wr_en_n low, bank_sel = 2'b00, clk_en high on that edge and the edge before) with legal fields updates the decoded outputs and sets cfg_valid on the same edge; cfg_valid then stays high until reset.
- R3: adr[2:0] selects the burst length: 3'b001 gives 2 beats, 3'b010 gives 4, 3'b011 gives 8, 3'b111 gives PAGE_BEATS (256 by default); any other code is refused.
- R4: adr[3] selects the burst type, 0 sequential and 1 interleaved (burst_interleave); a page-length burst together with adr[3] = 1 is refused.
- R5: adr[6:4] selects the CAS latency: 3'b010 gives 2 and 3'b011 gives 3; any other code is refused.
- R6: adr[7] is stored and shown on test_mode; an accepted mode write with adr[8] = 1 raises dll_rst for exactly one cycle.
- R7: A write with bank_sel[1] = 1, or a mode write with any of adr[11:9] nonzero, is refused.
- R8: An extended write (bank_sel = 2'b01) that is accepted records that the extended register was written; a mode write before that is refused and cfg_valid stays low.
- R9: A write sampled while banks_idle is low is refused.
- R10: An accepted write drives busy high for MRD_CYCLES-1 cycles (1 by default); any command (sel_n low and not all three strobes high) sampled while busy is refused.
- R11: A command sampled while clk_en is low, or on the first edge after clk_en returns high, is ignored: no error, no update.
- R12: A refused command raises cfg_err for one cycle per refused command and leaves burst_beats, burst_interleave, cas_lat, test_mode and cfg_valid unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Command bus clock enable |
| sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| adr | input | 12 | Address bits carrying the register value |
| bank_sel | input | 2 | Bank bits; bit 0 picks the extended register |
| banks_idle | input | 1 | High when every bank is precharged |
| burst_beats | output | 9 | Decoded burst length in beats |
| burst_interleave | output | 1 | 1 for interleaved burst order |
| cas_lat | output | 2 | Decoded CAS latency in cycles |
| test_mode | output | 1 | Stored test mode bit |
| dll_rst | output | 1 | One-cycle DLL reset request |
| cfg_valid | output | 1 | A legal mode write has been captured |
| cfg_err | output | 1 | One-cycle pulse for a refused command |
| busy | output | 1 | Settle window after an accepted write |

## Verification
Every result of this block is registered once, so the decoded fields, cfg_valid, cfg_err, dll_rst and the rise of busy all appear on the edge that samples the command; busy falls MRD_CYCLES-1 edges later and dll_rst falls one edge later. The bench changes inputs on the falling edge, lets one rising edge pass, and reads the outputs on the next falling edge, so each check lands in the cycle where the value is due. Checks of pulse length and busy length read again one falling edge later, and the busy test puts its second command on the very next edge so that it meets the window.

// File: rtl/sdr_mrs_pkg.sv
package sdr_mrs_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_WRREG = 2'd1,
    CMD_OTHER = 2'd2
  } cmd_kind_e;

  typedef struct packed {
    logic [1:0] bank;
    logic [2:0] upper;
    logic       dll;
    logic       test;
    logic [2:0] cl_code;
    logic       interleave;
    logic [2:0] bl_code;
  } mrs_word_t;

  function automatic mrs_word_t split_word(input logic [11:0] a, input logic [1:0] ba);
    mrs_word_t w;
    w.bank       = ba;
    w.upper      = a[11:9];
    w.dll        = a[8];
    w.test       = a[7];
    w.cl_code    = a[6:4];
    w.interleave = a[3];
    w.bl_code    = a[2:0];
    return w;
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_mrs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clk_en,
  input  logic      sel_n,
  input  logic      row_strobe_n,
  input  logic      col_strobe_n,
  input  logic      wr_en_n,
  output cmd_kind_e cmd_kind
);

  logic cke_prev_q;
  logic cke_prev_d;

  always_comb begin
    cke_prev_d = clk_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_prev_q <= 1'b0;
    else        cke_prev_q <= cke_prev_d;
  end

  always_comb begin
    cmd_kind = CMD_NONE;
    if (clk_en && cke_prev_q && !sel_n) begin
      if (!row_strobe_n && !col_strobe_n && !wr_en_n)
        cmd_kind = CMD_WRREG;
      else if (!(row_strobe_n && col_strobe_n && wr_en_n))
        cmd_kind = CMD_OTHER;
    end
  end

endmodule

// File: rtl/sdr_mode_check.sv
module sdr_mode_check
  import sdr_mrs_pkg::*;
#(
  parameter int PAGE_BEATS = 256,
  localparam int BEATS_W   = $clog2(PAGE_BEATS + 1)
) (
  input  mrs_word_t          word,
  output logic               word_ok,
  output logic [BEATS_W-1:0] beats,
  output logic [1:0]         cl
);

  logic bl_ok;
  logic cl_ok;

  always_comb begin
    beats = '0;
    bl_ok = 1'b0;
    case (word.bl_code)
      3'd1: begin beats = BEATS_W'(2); bl_ok = 1'b1; end
      3'd2: begin beats = BEATS_W'(4); bl_ok = 1'b1; end
      3'd3: begin beats = BEATS_W'(8); bl_ok = 1'b1; end
      3'd7: begin beats = BEATS_W'(PAGE_BEATS); bl_ok = !word.interleave; end
      default: begin beats = '0; bl_ok = 1'b0; end
    endcase
  end

  always_comb begin
    cl    = 2'd0;
    cl_ok = 1'b0;
    case (word.cl_code)
      3'd2: begin cl = 2'd2; cl_ok = 1'b1; end
      3'd3: begin cl = 2'd3; cl_ok = 1'b1; end
      default: begin cl = 2'd0; cl_ok = 1'b0; end
    endcase
  end

  always_comb begin
    word_ok = bl_ok && cl_ok && (word.upper == 3'd0);
  end

endmodule

// File: rtl/sdr_mrd_timer.sv
module sdr_mrd_timer #(
  parameter int MRD_CYCLES = 2,
  localparam int CNT_W     = (MRD_CYCLES > 2) ? $clog2(MRD_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  generate
    if (MRD_CYCLES <= 1) begin : g_no_wait
      assign busy = 1'b0;
    end else begin : g_wait
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             cnt_en;

      always_comb begin
        cnt_en = start || (cnt_q != '0);
        if (start) cnt_d = CNT_W'(MRD_CYCLES - 1);
        else       cnt_d = cnt_q - CNT_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign busy = (cnt_q != '0);
    end
  endgenerate

endmodule

// File: rtl/sdr_mode_capture.sv
module sdr_mode_capture
  import sdr_mrs_pkg::*;
#(
  parameter int PAGE_BEATS = 256,
  parameter int MRD_CYCLES = 2,
  parameter int SYNC_DEPTH = 2,
  localparam int BEATS_W   = $clog2(PAGE_BEATS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en,
  input  logic               sel_n,
  input  logic               row_strobe_n,
  input  logic               col_strobe_n,
  input  logic               wr_en_n,
  input  logic [11:0]        adr,
  input  logic [1:0]         bank_sel,
  input  logic               banks_idle,
  output logic [BEATS_W-1:0] burst_beats,
  output logic               burst_interleave,
  output logic [1:0]         cas_lat,
  output logic               test_mode,
  output logic               dll_rst,
  output logic               cfg_valid,
  output logic               cfg_err,
  output logic               busy
);

  // reset: asynchronous assert, synchronous release
  logic [SYNC_DEPTH-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_DEPTH-1];

  // command classification
  cmd_kind_e cmd_kind;

  sdr_cmd_decode u_decode (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .clk_en       (clk_en),
    .sel_n        (sel_n),
    .row_strobe_n (row_strobe_n),
    .col_strobe_n (col_strobe_n),
    .wr_en_n      (wr_en_n),
    .cmd_kind     (cmd_kind)
  );

  // field check and decode
  mrs_word_t          word;
  logic               word_ok;
  logic [BEATS_W-1:0] beats_dec;
  logic [1:0]         cl_dec;

  assign word = split_word(adr, bank_sel);

  sdr_mode_check #(.PAGE_BEATS(PAGE_BEATS)) u_check (
    .word    (word),
    .word_ok (word_ok),
    .beats   (beats_dec),
    .cl      (cl_dec)
  );

  // settle window
  logic accept;
  logic busy_w;

  sdr_mrd_timer #(.MRD_CYCLES(MRD_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (accept),
    .busy  (busy_w)
  );
  assign busy = busy_w;

  // state
  logic               ext_done_q, ext_done_d;
  logic               valid_q,    valid_d;
  logic               err_q,      err_d;
  logic               dll_q,      dll_d;
  logic [BEATS_W-1:0] beats_q;
  logic               inter_q;
  logic [1:0]         cl_q;
  logic               test_q;
  logic               mode_en;
  logic               refuse;
  logic               is_ext;

  always_comb begin
    is_ext = word.bank[0];
    refuse = 1'b0;
    if (cmd_kind == CMD_WRREG) begin
      if (busy_w || !banks_idle || word.bank[1])
        refuse = 1'b1;
      else if (!is_ext && (!ext_done_q || !word_ok))
        refuse = 1'b1;
    end else if (cmd_kind == CMD_OTHER) begin
      refuse = busy_w;
    end

    accept     = (cmd_kind == CMD_WRREG) && !refuse;
    mode_en    = accept && !is_ext;
    ext_done_d = ext_done_q || (accept && is_ext);
    valid_d    = valid_q || mode_en;
    err_d      = refuse;
    dll_d      = mode_en && word.dll;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ext_done_q <= 1'b0;
      valid_q    <= 1'b0;
      err_q      <= 1'b0;
      dll_q      <= 1'b0;
    end else begin
      ext_done_q <= ext_done_d;
      valid_q    <= valid_d;
      err_q      <= err_d;
      dll_q      <= dll_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      beats_q <= '0;
      inter_q <= 1'b0;
      cl_q    <= 2'd0;
      test_q  <= 1'b0;
    end else if (mode_en) begin
      beats_q <= beats_dec;
      inter_q <= word.interleave;
      cl_q    <= cl_dec;
      test_q  <= word.test;
    end
  end

  assign burst_beats      = beats_q;
  assign burst_interleave = inter_q;
  assign cas_lat          = cl_q;
  assign test_mode        = test_q;
  assign dll_rst          = dll_q;
  assign cfg_valid        = valid_q;
  assign cfg_err          = err_q;

endmodule

// File: rtl/sdr_mode_capture_chk.sv
module sdr_mode_capture_chk #(
  parameter int PAGE_BEATS = 256,
  localparam int BEATS_W   = $clog2(PAGE_BEATS + 1)
) (
  input logic               clk,
  input logic               rst_ok,
  input logic [BEATS_W-1:0] burst_beats,
  input logic               burst_interleave,
  input logic [1:0]         cas_lat,
  input logic               test_mode,
  input logic               dll_rst,
  input logic               cfg_valid,
  input logic               cfg_err,
  input logic               busy
);

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_valid |=> cfg_valid);

  assert_beats_legal_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_valid |-> (burst_beats == BEATS_W'(2) || burst_beats == BEATS_W'(4) ||
                   burst_beats == BEATS_W'(8) || burst_beats == BEATS_W'(PAGE_BEATS)));

  assert_page_seq_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_valid && burst_beats == BEATS_W'(PAGE_BEATS)) |-> !burst_interleave);

  assert_cl_legal_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_valid |-> (cas_lat == 2'd2 || cas_lat == 2'd3));

  assert_dll_single_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    dll_rst |=> !dll_rst);

  assert_dll_with_write_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    dll_rst |-> (cfg_valid && busy && !cfg_err));

  assert_write_starts_busy_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(cfg_valid) |-> busy);

  assert_err_holds_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    cfg_err |-> ($stable(burst_beats) && $stable(burst_interleave) &&
                 $stable(cas_lat) && $stable(test_mode) && $stable(cfg_valid)));

endmodule

bind sdr_mode_capture sdr_mode_capture_chk #(.PAGE_BEATS(PAGE_BEATS)) i_chk (
  .clk              (clk),
  .rst_ok           (rst_sync_n),
  .burst_beats      (burst_beats),
  .burst_interleave (burst_interleave),
  .cas_lat          (cas_lat),
  .test_mode        (test_mode),
  .dll_rst          (dll_rst),
  .cfg_valid        (cfg_valid),
  .cfg_err          (cfg_err),
  .busy             (busy)
);

// File: tb/test_sdr_mode_capture.sv
module test_sdr_mode_capture;

  localparam int PAGE = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        sel_n = 1'b1;
  logic        row_strobe_n = 1'b1;
  logic        col_strobe_n = 1'b1;
  logic        wr_en_n = 1'b1;
  logic [11:0] adr = '0;
  logic [1:0]  bank_sel = '0;
  logic        banks_idle = 1'b1;
  logic [8:0]  burst_beats;
  logic        burst_interleave;
  logic [1:0]  cas_lat;
  logic        test_mode;
  logic        dll_rst;
  logic        cfg_valid;
  logic        cfg_err;
  logic        busy;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdr_mode_capture i_sdr_mode_capture (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_n(sel_n),
    .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n),
    .adr(adr), .bank_sel(bank_sel), .banks_idle(banks_idle),
    .burst_beats(burst_beats), .burst_interleave(burst_interleave), .cas_lat(cas_lat),
    .test_mode(test_mode), .dll_rst(dll_rst), .cfg_valid(cfg_valid),
    .cfg_err(cfg_err), .busy(busy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] word(input int bl, input int bt, input int cl,
                                       input int tm, input int dl, input int up);
    return {up[2:0], dl[0], tm[0], cl[2:0], bt[0], bl[2:0]};
  endfunction

  // drive at a falling edge, let one rising edge pass, return at next falling edge
  task automatic issue(input logic [2:0] strobes, input logic [11:0] a, input logic [1:0] ba);
    sel_n = 1'b0;
    {row_strobe_n, col_strobe_n, wr_en_n} = strobes;
    adr = a;
    bank_sel = ba;
    @(posedge clk);
    @(negedge clk);
    sel_n = 1'b1;
    {row_strobe_n, col_strobe_n, wr_en_n} = 3'b111;
    adr = '0;
    bank_sel = '0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    wait_cyc(3);
    check("R1", "valid in reset", cfg_valid, 0);
    check("R1", "err in reset", cfg_err, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R1", "valid", cfg_valid, 0);
    check("R1", "err", cfg_err, 0);
    check("R1", "busy", busy, 0);
    check("R1", "dll", dll_rst, 0);
  endtask

  task automatic t_mode_before_ext;
    issue(3'b000, word(1, 0, 2, 0, 0, 0), 2'b00);
    check("R8", "err on early mode write", cfg_err, 1);
    check("R8", "valid stays low", cfg_valid, 0);
    check("R8", "no busy", busy, 0);
    wait_cyc(1);
    check("R12", "err one cycle", cfg_err, 0);
  endtask

  task automatic t_ext_write;
    issue(3'b000, 12'h000, 2'b01);
    check("R8", "ext accepted", cfg_err, 0);
    check("R10", "busy after ext", busy, 1);
    check("R8", "valid after ext", cfg_valid, 0);
    wait_cyc(1);
    check("R10", "busy ends", busy, 0);
  endtask

  task automatic t_burst_len;
    int codes[4] = '{1, 2, 3, 7};
    int beats[4] = '{2, 4, 8, PAGE};
    foreach (codes[i]) begin
      issue(3'b000, word(codes[i], 0, 2, 0, 0, 0), 2'b00);
      check("R3", "len accepted", cfg_err, 0);
      check("R3", "beats", burst_beats, beats[i]);
      check("R2", "valid", cfg_valid, 1);
      check("R2", "cl", cas_lat, 2);
      wait_cyc(1);
    end
    issue(3'b000, word(0, 0, 2, 0, 0, 0), 2'b00);
    check("R3", "code 0 refused", cfg_err, 1);
    check("R12", "beats kept", burst_beats, PAGE);
    wait_cyc(1);
    issue(3'b000, word(5, 0, 3, 0, 0, 0), 2'b00);
    check("R3", "code 5 refused", cfg_err, 1);
    check("R12", "cl kept", cas_lat, 2);
    wait_cyc(1);
  endtask

  task automatic t_burst_type;
    issue(3'b000, word(2, 1, 2, 0, 0, 0), 2'b00);
    check("R4", "interleave set", burst_interleave, 1);
    check("R4", "beats 4", burst_beats, 4);
    wait_cyc(1);
    issue(3'b000, word(7, 1, 2, 0, 0, 0), 2'b00);
    check("R4", "page interleave refused", cfg_err, 1);
    check("R12", "beats kept", burst_beats, 4);
    wait_cyc(1);
    issue(3'b000, word(3, 0, 2, 0, 0, 0), 2'b00);
    check("R4", "sequential", burst_interleave, 0);
    wait_cyc(1);
  endtask

  task automatic t_cas;
    issue(3'b000, word(1, 0, 3, 0, 0, 0), 2'b00);
    check("R5", "cl 3", cas_lat, 3);
    wait_cyc(1);
    issue(3'b000, word(2, 0, 1, 0, 0, 0), 2'b00);
    check("R5", "cl code 1 refused", cfg_err, 1);
    check("R12", "cl kept", cas_lat, 3);
    check("R12", "beats kept", burst_beats, 2);
    wait_cyc(1);
    issue(3'b000, word(2, 0, 4, 0, 0, 0), 2'b00);
    check("R5", "cl code 4 refused", cfg_err, 1);
    wait_cyc(1);
  endtask

  task automatic t_test_dll;
    issue(3'b000, word(2, 0, 2, 1, 0, 0), 2'b00);
    check("R6", "test mode", test_mode, 1);
    check("R6", "no dll", dll_rst, 0);
    wait_cyc(1);
    issue(3'b000, word(2, 0, 2, 0, 1, 0), 2'b00);
    check("R6", "dll pulse", dll_rst, 1);
    check("R6", "test cleared", test_mode, 0);
    wait_cyc(1);
    check("R6", "dll one cycle", dll_rst, 0);
  endtask

  task automatic t_upper_bank;
    issue(3'b000, word(2, 0, 2, 0, 0, 1), 2'b00);
    check("R7", "upper bit refused", cfg_err, 1);
    wait_cyc(1);
    issue(3'b000, word(8 - 5, 0, 3, 0, 0, 0), 2'b10);
    check("R7", "bank bit1 refused", cfg_err, 1);
    check("R12", "cl kept", cas_lat, 2);
    wait_cyc(1);
  endtask

  task automatic t_idle;
    banks_idle = 1'b0;
    issue(3'b000, word(3, 0, 3, 0, 0, 0), 2'b00);
    check("R9", "not idle refused", cfg_err, 1);
    check("R9", "beats kept", burst_beats, 4);
    banks_idle = 1'b1;
    wait_cyc(1);
  endtask

  task automatic t_busy;
    issue(3'b000, word(3, 0, 3, 0, 0, 0), 2'b00);
    check("R10", "busy after write", busy, 1);
    issue(3'b000, word(1, 1, 2, 0, 0, 0), 2'b00);
    check("R10", "write in window refused", cfg_err, 1);
    check("R10", "beats kept", burst_beats, 8);
    check("R10", "busy ended", busy, 0);
    issue(3'b000, word(1, 0, 2, 0, 0, 0), 2'b00);
    check("R10", "write after window", cfg_err, 0);
    issue(3'b011, 12'h000, 2'b00);
    check("R10", "other cmd in window refused", cfg_err, 1);
    issue(3'b011, 12'h000, 2'b00);
    check("R10", "other cmd outside window", cfg_err, 0);
    wait_cyc(1);
  endtask

  task automatic t_cke;
    clk_en = 1'b0;
    issue(3'b000, word(3, 0, 3, 0, 0, 0), 2'b00);
    check("R11", "cke low no err", cfg_err, 0);
    check("R11", "cke low no update", burst_beats, 2);
    clk_en = 1'b1;
    issue(3'b000, word(3, 0, 3, 0, 0, 0), 2'b00);
    check("R11", "first edge no update", burst_beats, 2);
    check("R11", "first edge no busy", busy, 0);
    issue(3'b000, word(3, 0, 3, 0, 0, 0), 2'b00);
    check("R11", "then accepted", burst_beats, 8);
    wait_cyc(1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_mode_before_ext();
    t_ext_write();
    t_burst_len();
    t_burst_type();
    t_cas();
    t_test_dll();
    t_upper_bank();
    t_idle();
    t_busy();
    t_cke();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule